// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects 32 level-sensitive request lines and drives two request outputs towards a processor core: a fast-interrupt line and an ordinary IRQ line. Each request has an enable bit and a class bit. An enabled request whose class bit is set counts as a fast interrupt. An enabled request whose class bit is clear counts as an IRQ. A request that is not enabled reaches neither output. The fast class ranks above both IRQ kinds.

Sixteen vector slots give IRQ sources a handler address. Each slot holds a source number, a slot-enable bit and a 32-bit address. When software reads the vector register, it gets the address of the lowest-numbered slot whose source is an active IRQ. Slot 0 has the highest priority. If no slot matches, the read returns a shared default address. That default serves every non-vectored IRQ.

All configuration and status sit behind a simple word-wide register port. Writes are taken on the clock edge. Reads are combinational from the current address.

Top module: `vic_top`

## Requirements
- R1: After reset, these values are zero: the enables, the class bits, every slot control, every slot address and the default address. Both outputs are low even with every request asserted.
- R2: A write to the enable register (word offset 0x01) sets the enable bits where the written data has ones. Bits written as zero keep their value. A read of offset 0x01 returns the current enables.
- R3: A write to the enable-clear register (offset 0x02) clears the enable bits where the written data has ones. Other enables are unchanged.
- R4: `fiq_o` is high exactly when some request is asserted, enabled and has its class bit set. The class register is at offset 0x03, and 1 means fast.
- R5: `irq_o` is high exactly when some request is asserted, enabled and has its class bit clear. This holds whether or not a slot refers to that request.
- R6: A request whose enable bit is clear has no effect on `fiq_o`, on `irq_o` or on the vector read.
- R7: A read of the vector register (offset 0x06) returns the address of the lowest-numbered matching slot. A slot matches when its source is asserted, enabled and of IRQ class.
- R8: A slot takes part only when its enable bit is set. Slot control registers are at offsets 0x10 to 0x1F, with the enable at bit 5 and the source number at bits 4:0. A slot whose source is classified fast never supplies the vector.
- R9: When no slot matches, the vector read returns the default address register (offset 0x07, read/write).
- R10: Status reads return the asserted requests (offset 0x00), the active fast requests (offset 0x04) and the active IRQ requests (offset 0x05), one bit per request.
- R11: Slot control and slot address registers (offsets 0x20 to 0x2F) read back what was last written. Bits 31:6 of slot control read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 32 | Interrupt request lines, active high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the current offset |
| fiq_o | output | 1 | Fast-interrupt request to the core |
| irq_o | output | 1 | IRQ request to the core |

## Verification
The bench drives several requests at once. It checks that the lowest-numbered matching slot wins and that a slot far down the list, slot 15, still supplies its address when it is alone. A design that scanned slots from the wrong end would return the wrong handler for these cases.

It also covers sources that must not produce a vector:
- a source mapped to a slot but classified fast, which should raise only `fiq_o`;
- a source whose slot is disabled;
- a source whose enable was removed through the clear register.

A design that ignored the class bit or the slot enable in the slot match would hand out a vector instead of the default address. A write-one-to-set that is wrongly implemented as a plain store shows up as lost enables after a write of zeros.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_RAW   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_EN    = 6'h01;
    localparam logic [ADDR_W-1:0] OFS_ENCLR = 6'h02;
    localparam logic [ADDR_W-1:0] OFS_CLASS = 6'h03;
    localparam logic [ADDR_W-1:0] OFS_FAST  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_IRQST = 6'h05;
    localparam logic [ADDR_W-1:0] OFS_VEC   = 6'h06;
    localparam logic [ADDR_W-1:0] OFS_DFLT  = 6'h07;

    localparam logic [1:0] REGION_MISC = 2'b00;
    localparam logic [1:0] REGION_CTL  = 2'b01;
    localparam logic [1:0] REGION_VEC  = 2'b10;

endpackage

// File: rtl/vic_src_gate.sv
module vic_src_gate #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] cls_i,
    output logic [NSRC-1:0] fast_act_o,
    output logic [NSRC-1:0] irq_act_o,
    output logic            fiq_o,
    output logic            irq_o
);

    always_comb begin
        fast_act_o = req_i & en_i & cls_i;
        irq_act_o  = req_i & en_i & ~cls_i;
        fiq_o      = |fast_act_o;
        irq_o      = |irq_act_o;
    end

    // R4 / R6: a fast request needs an asserted, enabled source
    a_r4_fiq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> ((req_i & en_i) != '0));
    // R5 / R6: an IRQ needs an asserted, enabled source
    a_r5_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((req_i & en_i) != '0));
    // R6: nothing enabled, nothing raised
    a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & en_i) == '0) |-> (!fiq_o && !irq_o));

endmodule

// File: rtl/vic_slot_match.sv
module vic_slot_match #(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    localparam int SRCW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]             irq_act_i,
    input  logic [NSLOT-1:0]            slot_en_i,
    input  logic [NSLOT-1:0][SRCW-1:0]  slot_src_i,
    output logic [NSLOT-1:0]            hit_o
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign hit_o[s] = slot_en_i[s] & irq_act_i[slot_src_i[s]];
    end

endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
    parameter int NSLOT = 16,
    localparam int IW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] hit_i,
    output logic             valid_o,
    output logic [IW-1:0]    idx_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (hit_i[s]) begin
                valid_o = 1'b1;
                idx_o   = IW'(s);
            end
        end
    end

    // R7: the chosen slot is really hitting
    a_r7_pick_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> hit_i[idx_o]);
    // R7: no lower-numbered slot is hitting
    a_r7_pick_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((hit_i & ((NSLOT'(1) << idx_o) - NSLOT'(1))) == '0));
    // R9: no pick while some slot hits is an error
    a_r9_pick_when_any: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i != '0) |-> valid_o);

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              fiq_o,
    output logic              irq_o
);

    localparam int SRCW = $clog2(NSRC);
    localparam int IW   = $clog2(NSLOT);

    typedef struct packed {
        logic [NSRC-1:0]             en;
        logic [NSRC-1:0]             cls;
        logic [DW-1:0]               dflt;
        logic [NSLOT-1:0]            slot_en;
        logic [NSLOT-1:0][SRCW-1:0]  slot_src;
        logic [NSLOT-1:0][DW-1:0]    slot_vec;
    } state_t;

    state_t st_q, st_d;

    logic [NSRC-1:0]  fast_act, irq_act;
    logic [NSLOT-1:0] slot_hit;
    logic             pick_valid;
    logic [IW-1:0]    pick_idx;
    logic [DW-1:0]    vec_addr;

    logic [1:0]    region;
    logic [IW-1:0] reg_slot;
    assign region   = reg_addr_i[ADDR_W-1:ADDR_W-2];
    assign reg_slot = reg_addr_i[IW-1:0];

    vic_src_gate #(.NSRC(NSRC)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .req_i(req_i), .en_i(st_q.en), .cls_i(st_q.cls),
        .fast_act_o(fast_act), .irq_act_o(irq_act),
        .fiq_o(fiq_o), .irq_o(irq_o)
    );

    vic_slot_match #(.NSRC(NSRC), .NSLOT(NSLOT)) u_match (
        .irq_act_i(irq_act), .slot_en_i(st_q.slot_en),
        .slot_src_i(st_q.slot_src), .hit_o(slot_hit)
    );

    vic_prio_pick #(.NSLOT(NSLOT)) u_pick (
        .clk(clk), .rst_n(rst_n), .hit_i(slot_hit),
        .valid_o(pick_valid), .idx_o(pick_idx)
    );

    assign vec_addr = pick_valid ? st_q.slot_vec[pick_idx] : st_q.dflt;

    always_comb begin
        st_d = st_q;
        if (reg_wr_i) begin
            unique case (region)
                REGION_MISC: begin
                    case (reg_addr_i)
                        OFS_EN:    st_d.en   = st_q.en | reg_wdata_i[NSRC-1:0];
                        OFS_ENCLR: st_d.en   = st_q.en & ~reg_wdata_i[NSRC-1:0];
                        OFS_CLASS: st_d.cls  = reg_wdata_i[NSRC-1:0];
                        OFS_DFLT:  st_d.dflt = reg_wdata_i;
                        default: ;
                    endcase
                end
                REGION_CTL: begin
                    st_d.slot_en[reg_slot]  = reg_wdata_i[SRCW];
                    st_d.slot_src[reg_slot] = reg_wdata_i[SRCW-1:0];
                end
                REGION_VEC: st_d.slot_vec[reg_slot] = reg_wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (region)
            REGION_MISC: begin
                case (reg_addr_i)
                    OFS_RAW:   reg_rdata_o = DW'(req_i);
                    OFS_EN:    reg_rdata_o = DW'(st_q.en);
                    OFS_CLASS: reg_rdata_o = DW'(st_q.cls);
                    OFS_FAST:  reg_rdata_o = DW'(fast_act);
                    OFS_IRQST: reg_rdata_o = DW'(irq_act);
                    OFS_VEC:   reg_rdata_o = vec_addr;
                    OFS_DFLT:  reg_rdata_o = st_q.dflt;
                    default:   reg_rdata_o = '0;
                endcase
            end
            REGION_CTL: reg_rdata_o = DW'({st_q.slot_en[reg_slot], st_q.slot_src[reg_slot]});
            REGION_VEC: reg_rdata_o = st_q.slot_vec[reg_slot];
            default:    reg_rdata_o = '0;
        endcase
    end

    // R2: every one written to the set register is present afterwards
    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFS_EN) |=>
        ((st_q.en & $past(reg_wdata_i[NSRC-1:0])) == $past(reg_wdata_i[NSRC-1:0])));
    // R2: a set write never drops an enable
    a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFS_EN) |=> (($past(st_q.en) & ~st_q.en) == '0));
    // R3: every one written to the clear register is gone afterwards
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFS_ENCLR) |=>
        ((st_q.en & $past(reg_wdata_i[NSRC-1:0])) == '0));
    // R3: a clear write never adds an enable
    a_r3_clear_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFS_ENCLR) |=> ((st_q.en & ~$past(st_q.en)) == '0));
    // R7 / R8: a vectored slot can only win while the IRQ line is up
    a_r7_vector_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> irq_o);

endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
    import vic_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DFLT = 32'hDEAD_0000;
    localparam logic [31:0] V3   = 32'h1000_0300;
    localparam logic [31:0] V5   = 32'h1000_0500;
    localparam logic [31:0] V4   = 32'h1000_0400;
    localparam int NVEC = 13;

    // {req, fiq, irq, vector}
    localparam logic [65:0] TBL [NVEC] = '{
        {32'h0000_0000, 1'b0, 1'b0, DFLT},
        {32'h0000_0002, 1'b1, 1'b0, DFLT},
        {32'h0000_0008, 1'b0, 1'b1, V3},
        {32'h0000_0020, 1'b0, 1'b1, V5},
        {32'h0000_0028, 1'b0, 1'b1, V3},
        {32'h0000_0010, 1'b0, 1'b1, V4},
        {32'h0000_0030, 1'b0, 1'b1, V5},
        {32'h0000_0040, 1'b0, 1'b1, DFLT},
        {32'h0000_0080, 1'b0, 1'b0, DFLT},
        {32'h0010_0000, 1'b0, 1'b0, DFLT},
        {32'h0000_000A, 1'b1, 1'b1, V3},
        {32'h0000_0001, 1'b0, 1'b1, DFLT},
        {32'hFFFF_FFFF, 1'b1, 1'b1, V3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fiq, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vic_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        req = 32'hFFFF_FFFF;
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1 fiq", {31'b0, fiq}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rreg(OFS_EN, v);    check("R1 enables", v, 32'h0);
        rreg(OFS_CLASS, v); check("R1 class", v, 32'h0);
        rreg(OFS_VEC, v);   check("R1 vector", v, 32'h0);
        rreg(6'h1F, v);     check("R1 slot15 ctl", v, 32'h0);
        rreg(6'h20, v);     check("R1 slot0 addr", v, 32'h0);

        // configuration
        req = '0;
        wreg(OFS_EN, 32'h0000_00FF);
        wreg(OFS_ENCLR, 32'h0000_0080);
        wreg(OFS_CLASS, 32'h0000_0002);
        wreg(OFS_DFLT, DFLT);
        wreg(6'h10, 32'h23); wreg(6'h20, V3);           // slot0 -> src3
        wreg(6'h11, 32'h25); wreg(6'h21, V5);           // slot1 -> src5
        wreg(6'h12, 32'h21); wreg(6'h22, 32'h1000_0100); // slot2 -> src1 (fast)
        wreg(6'h13, 32'h06); wreg(6'h23, 32'h1000_0600); // slot3 -> src6, disabled
        wreg(6'h1F, 32'h24); wreg(6'h2F, V4);           // slot15 -> src4

        rreg(OFS_EN, v);   check("R3 enable after clear", v, 32'h0000_007F);
        wreg(OFS_EN, 32'h0);
        rreg(OFS_EN, v);   check("R2 zeros have no effect", v, 32'h0000_007F);
        rreg(OFS_DFLT, v); check("R9 default readback", v, DFLT);
        rreg(6'h12, v);    check("R11 slot2 ctl readback", v, 32'h21);
        rreg(6'h13, v);    check("R11 slot3 ctl readback", v, 32'h06);
        rreg(6'h2F, v);    check("R11 slot15 addr readback", v, V4);

        // table walk: R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            req = TBL[i][65:34];
            addr = OFS_VEC;
            #1;
            check($sformatf("R4 fiq vec%0d", i), {31'b0, fiq}, {31'b0, TBL[i][33]});
            check($sformatf("R5 irq vec%0d", i), {31'b0, irq}, {31'b0, TBL[i][32]});
            check($sformatf("R7 R8 R9 vector vec%0d", i), rdata, TBL[i][31:0]);
        end

        // R10: status readouts with everything asserted
        req = 32'hFFFF_FFFF;
        rreg(OFS_RAW, v);   check("R10 raw", v, 32'hFFFF_FFFF);
        rreg(OFS_FAST, v);  check("R10 fast status", v, 32'h0000_0002);
        rreg(OFS_IRQST, v); check("R10 irq status", v, 32'h0000_007D);

        // R8: disable slot0, slot1 takes over for src3+src5
        req = 32'h0000_0028;
        wreg(6'h10, 32'h03);
        rreg(OFS_VEC, v);  check("R8 disabled slot0 skipped", v, V5);
        // R6: remove enable of src5 -> nothing vectored, irq from src3 remains
        wreg(OFS_ENCLR, 32'h0000_0020);
        rreg(OFS_VEC, v);  check("R6 cleared source not vectored", v, DFLT);
        check("R5 irq from unvectored src3", {31'b0, irq}, 32'h1);
        // R4: reclassify src3 as fast -> fiq up, irq down
        wreg(OFS_CLASS, 32'h0000_000A);
        #1;
        check("R4 fiq after reclass", {31'b0, fiq}, 32'h1);
        check("R5 irq after reclass", {31'b0, irq}, 32'h0);
        // R2: set again restores src5
        wreg(OFS_EN, 32'h0000_0020);
        rreg(OFS_EN, v);   check("R2 re-set", v, 32'h0000_007F);
        rreg(OFS_VEC, v);  check("R7 src5 vectored again", v, V5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule